// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Predecoder

This block sits at the front of a small 64-bit processor whose instructions are 1, 2, 9 or 10 bytes long. It receives a 10-byte little-endian window read from instruction memory at the current fetch address, together with that address and a memory-error flag. From the window it pulls out the opcode class, the function code, two register specifiers and a 64-bit constant. It then works out the address of the next sequential instruction and a predicted next fetch address.

Two per-opcode predicates set the instruction length: whether the opcode carries a register byte, and whether it carries a constant word. Jumps and calls are predicted taken, so the fetch is redirected to their embedded constant. A memory error turns the fetched instruction into a no-op with an address-error status.

Every decoded output is combinational. A single register holds the predicted address for the next cycle. It is loaded on each clock edge unless the hold input is high.

Top module: `fetch_predecode`

## Requirements
- R1: Window byte 0 (bits 7:0) supplies the opcode class in its upper nibble and the function code in its lower nibble. Byte 1 supplies reg_a in its upper nibble and reg_b in its lower nibble. Class encodings are: halt 0, nop 1, move 2, immediate move 3, store 4, load 5, ALU 6, jump 7, call 8, return 9, push A, pop B, add-immediate C.
- R2: Classes 2, 3, 4, 5, 6, A, B and C carry a register byte. For every other class, reg_a and reg_b read 0xF.
- R3: Classes 3, 4, 5, 7, 8 and C carry a constant word. The constant is assembled little-endian from 8 bytes starting at byte 2 when a register byte is present, and at byte 1 otherwise. When no constant is carried, imm is 0.
- R4: seq_pc equals fetch_pc + 1, plus 1 if a register byte is present, plus 8 if a constant is present, modulo 2^64.
- R5: When imem_err is high, op_class reads 1 (nop), op_fn reads 0 and stat reads 3, whatever the window holds. The outputs then follow a nop, so seq_pc is fetch_pc+1.
- R6: Classes 0 to C are valid and drive op_ok high. Classes D, E and F drive op_ok low and set stat to 0.
- R7: The stat encoding is invalid=0, OK=1, halt=2, address error=3. The priority is memory error, then invalid, then halt, then OK.
- R8: next_pc equals imm for classes 7 and 8, and seq_pc for every other class.
- R9: next_pc_q resets to 0. On each rising clock edge it loads next_pc when hold is low and keeps its value when hold is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hold | input | 1 | Holds next_pc_q when high |
| fetch_pc | input | 64 | Address the window was read from |
| win | input | 80 | Instruction bytes; byte 0 in bits 7:0 |
| imem_err | input | 1 | Instruction memory read error |
| op_class | output | 4 | Opcode class |
| op_fn | output | 4 | Function code |
| reg_a | output | 4 | First register specifier |
| reg_b | output | 4 | Second register specifier |
| imm | output | 64 | Constant word |
| seq_pc | output | 64 | Next sequential address |
| next_pc | output | 64 | Predicted next fetch address |
| op_ok | output | 1 | Opcode is valid |
| stat | output | 2 | Status code |
| next_pc_q | output | 64 | Registered predicted address |

## Verification
The error override and the branch prediction can act in the same cycle: a window holding a jump or an invalid opcode arrives together with imem_err. The bench builds this case directly. It passes only if the constant is not used as the prediction and the opcode validity check is not applied: next_pc must equal fetch_pc+1 and stat must read 3. The bench also changes the window while hold is high, to show that the prediction is computed but not loaded into the register.

// File: rtl/fetch_predecode.sv
module fetch_predecode #(
  parameter int WORD_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [WORD_W-1:0] fetch_pc,
  input  logic [WORD_W+15:0] win,
  input  logic              imem_err,
  output logic [3:0]        op_class,
  output logic [3:0]        op_fn,
  output logic [3:0]        reg_a,
  output logic [3:0]        reg_b,
  output logic [WORD_W-1:0] imm,
  output logic [WORD_W-1:0] seq_pc,
  output logic [WORD_W-1:0] next_pc,
  output logic              op_ok,
  output logic [1:0]        stat,
  output logic [WORD_W-1:0] next_pc_q
);
  localparam logic [3:0] C_HALT = 4'h0, C_NOP = 4'h1, C_MOV = 4'h2, C_IMOV = 4'h3,
                         C_ST = 4'h4, C_LD = 4'h5, C_ALU = 4'h6, C_JMP = 4'h7,
                         C_CALL = 4'h8, C_RET = 4'h9, C_PUSH = 4'hA, C_POP = 4'hB,
                         C_IADD = 4'hC;
  localparam logic [1:0] S_INV = 2'd0, S_OK = 2'd1, S_HLT = 2'd2, S_ADR = 2'd3;
  localparam int CONST_BYTES = WORD_W / 8;

  logic has_reg, has_const, known;

  assign op_class = imem_err ? C_NOP : win[7:4];
  assign op_fn    = imem_err ? 4'h0  : win[3:0];

  always_comb begin
    has_reg   = 1'b0;
    has_const = 1'b0;
    known     = 1'b1;
    case (op_class)
      C_MOV, C_ALU, C_PUSH, C_POP: has_reg = 1'b1;
      C_IMOV, C_ST, C_LD, C_IADD: begin has_reg = 1'b1; has_const = 1'b1; end
      C_JMP, C_CALL:               has_const = 1'b1;
      C_HALT, C_NOP, C_RET:        ;
      default:                     known = 1'b0;
    endcase
  end

  assign reg_a = has_reg ? win[15:12] : 4'hF;
  assign reg_b = has_reg ? win[11:8]  : 4'hF;

  assign imm = !has_const ? '0 : (has_reg ? win[16 +: WORD_W] : win[8 +: WORD_W]);

  assign seq_pc = fetch_pc + WORD_W'(1) + WORD_W'(has_reg)
                + (has_const ? WORD_W'(CONST_BYTES) : '0);

  assign next_pc = (op_class == C_JMP || op_class == C_CALL) ? imm : seq_pc;

  assign op_ok = known;
  assign stat  = imem_err ? S_ADR : !known ? S_INV : (op_class == C_HALT) ? S_HLT : S_OK;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     next_pc_q <= '0;
    else if (!hold) next_pc_q <= next_pc;
endmodule

// File: rtl/fetch_predecode_chk.sv
module fetch_predecode_chk #(
  parameter int WORD_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hold,
  input logic [WORD_W-1:0] fetch_pc,
  input logic [WORD_W+15:0] win,
  input logic              imem_err,
  input logic [3:0]        op_class,
  input logic [3:0]        op_fn,
  input logic [3:0]        reg_a,
  input logic [3:0]        reg_b,
  input logic [WORD_W-1:0] imm,
  input logic [WORD_W-1:0] seq_pc,
  input logic [WORD_W-1:0] next_pc,
  input logic              op_ok,
  input logic [1:0]        stat,
  input logic [WORD_W-1:0] next_pc_q
);
  logic [WORD_W-1:0] step;
  assign step = seq_pc - fetch_pc;

  p_err_nop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    imem_err |-> (op_class == 4'h1 && op_fn == 4'h0 && stat == 2'd3));

  p_bad_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!imem_err && win[7:4] > 4'hC) |-> (!op_ok && stat == 2'd0));

  p_len_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 1 || step == 2 || step == 9 || step == 10));

  p_no_regbyte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class inside {4'h0, 4'h1, 4'h7, 4'h8, 4'h9}) |-> (reg_a == 4'hF && reg_b == 4'hF));

  p_taken_pred_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_class == 4'h7 || op_class == 4'h8) |-> next_pc == imm);

  p_hold_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(next_pc_q));

  p_load_pred_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> next_pc_q == $past(next_pc));
endmodule

bind fetch_predecode fetch_predecode_chk #(.WORD_W(WORD_W)) u_chk (.*);

// File: tb/fetch_predecode_test.sv
`timescale 1ns/1ps
module fetch_predecode_test;
  typedef struct packed {
    logic [63:0] pc;
    logic [79:0] w;
    logic        err;
    logic [3:0]  cls;
    logic [3:0]  fn;
    logic [3:0]  ra;
    logic [3:0]  rb;
    logic [63:0] im;
    logic [63:0] seq;
    logic [63:0] pred;
    logic        ok;
    logic [1:0]  st;
  } vec_t;

  localparam logic [63:0] P = 64'h100;
  localparam logic [63:0] Q = 64'hFFFF_FFFF_FFFF_FFF8;
  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{P, 80'h00, 1'b0, 4'h0, 4'h0, 4'hF, 4'hF, 64'h0, P+1, P+1, 1'b1, 2'd2},
    '{P, 80'h10, 1'b0, 4'h1, 4'h0, 4'hF, 4'hF, 64'h0, P+1, P+1, 1'b1, 2'd1},
    '{P, 80'h4523, 1'b0, 4'h2, 4'h3, 4'h4, 4'h5, 64'h0, P+2, P+2, 1'b1, 2'd1},
    '{P, 80'h1122334455667788_F230, 1'b0, 4'h3, 4'h0, 4'hF, 4'h2, 64'h1122334455667788, P+10, P+10, 1'b1, 2'd1},
    '{P, 80'h0161, 1'b0, 4'h6, 4'h1, 4'h0, 4'h1, 64'h0, P+2, P+2, 1'b1, 2'd1},
    '{P, 80'hAB_0000000000000200_74, 1'b0, 4'h7, 4'h4, 4'hF, 4'hF, 64'h200, P+9, 64'h200, 1'b1, 2'd1},
    '{P, 80'h00_0000000000000400_80, 1'b0, 4'h8, 4'h0, 4'hF, 4'hF, 64'h400, P+9, 64'h400, 1'b1, 2'd1},
    '{P, 80'h90, 1'b0, 4'h9, 4'h0, 4'hF, 4'hF, 64'h0, P+1, P+1, 1'b1, 2'd1},
    '{P, 80'h3FA0, 1'b0, 4'hA, 4'h0, 4'h3, 4'hF, 64'h0, P+2, P+2, 1'b1, 2'd1},
    '{P, 80'h6FB0, 1'b0, 4'hB, 4'h0, 4'h6, 4'hF, 64'h0, P+2, P+2, 1'b1, 2'd1},
    '{P, 80'hFFFFFFFFFFFFFFF8_F3C0, 1'b0, 4'hC, 4'h0, 4'hF, 4'h3, 64'hFFFFFFFFFFFFFFF8, P+10, P+10, 1'b1, 2'd1},
    '{P, 80'h0000000000000010_1540, 1'b0, 4'h4, 4'h0, 4'h1, 4'h5, 64'h10, P+10, P+10, 1'b1, 2'd1},
    '{P, 80'h0000000000000008_7250, 1'b0, 4'h5, 4'h0, 4'h7, 4'h2, 64'h8, P+10, P+10, 1'b1, 2'd1},
    '{P, 80'h12D0, 1'b0, 4'hD, 4'h0, 4'hF, 4'hF, 64'h0, P+1, P+1, 1'b0, 2'd0},
    '{P, 80'hF5, 1'b0, 4'hF, 4'h5, 4'hF, 4'hF, 64'h0, P+1, P+1, 1'b0, 2'd0},
    '{P, 80'hAB_0000000000000200_74, 1'b1, 4'h1, 4'h0, 4'hF, 4'hF, 64'h0, P+1, P+1, 1'b1, 2'd3},
    '{P, 80'hE0, 1'b1, 4'h1, 4'h0, 4'hF, 4'hF, 64'h0, P+1, P+1, 1'b1, 2'd3},
    '{Q, 80'h0000000000000005_F130, 1'b0, 4'h3, 4'h0, 4'hF, 4'h1, 64'h5, 64'h2, 64'h2, 1'b1, 2'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0, hold = 1'b0, imem_err = 1'b0;
  logic [63:0] fetch_pc = '0;
  logic [79:0] win = '0;
  logic [3:0] op_class, op_fn, reg_a, reg_b;
  logic [63:0] imm, seq_pc, next_pc, next_pc_q;
  logic op_ok;
  logic [1:0] stat;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fetch_predecode uut (.clk(clk), .rst_n(rst_n), .hold(hold), .fetch_pc(fetch_pc), .win(win),
    .imem_err(imem_err), .op_class(op_class), .op_fn(op_fn), .reg_a(reg_a), .reg_b(reg_b),
    .imm(imm), .seq_pc(seq_pc), .next_pc(next_pc), .op_ok(op_ok), .stat(stat),
    .next_pc_q(next_pc_q));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #100000;
    if (!done) begin
      total++; bad++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - bad, total);
      $finish;
    end
  end

  initial begin
    hold = 1'b1;
    #12;
    chk("R9 reset value", next_pc_q, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      fetch_pc = VEC[i].pc; win = VEC[i].w; imem_err = VEC[i].err;
      #1;
      chk($sformatf("R1/R5 class v%0d", i), 64'(op_class), 64'(VEC[i].cls));
      chk($sformatf("R1/R5 fn v%0d", i), 64'(op_fn), 64'(VEC[i].fn));
      chk($sformatf("R2 reg_a v%0d", i), 64'(reg_a), 64'(VEC[i].ra));
      chk($sformatf("R2 reg_b v%0d", i), 64'(reg_b), 64'(VEC[i].rb));
      chk($sformatf("R3 imm v%0d", i), imm, VEC[i].im);
      chk($sformatf("R4 seq v%0d", i), seq_pc, VEC[i].seq);
      chk($sformatf("R8 pred v%0d", i), next_pc, VEC[i].pred);
      chk($sformatf("R6 ok v%0d", i), 64'(op_ok), 64'(VEC[i].ok));
      chk($sformatf("R7 stat v%0d", i), 64'(stat), 64'(VEC[i].st));
      @(negedge clk);
    end
    chk("R9 held through table", next_pc_q, 64'h0);

    fetch_pc = P; win = 80'hAB_0000000000000200_74; imem_err = 1'b0; hold = 1'b0;
    @(negedge clk);
    chk("R9 load jump target", next_pc_q, 64'h200);
    hold = 1'b1; win = 80'h00_0000000000000400_80;
    @(negedge clk);
    chk("R9 hold keeps", next_pc_q, 64'h200);
    chk("R8 call pred while held", next_pc, 64'h400);
    hold = 1'b0;
    @(negedge clk);
    chk("R9 load after release", next_pc_q, 64'h400);
    imem_err = 1'b1;
    @(negedge clk);
    chk("R5 error load seq", next_pc_q, P + 1);
    imem_err = 1'b0; win = 80'h4523;
    @(negedge clk);
    chk("R4 move load seq", next_pc_q, P + 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end
endmodule